// File: doc/BRIEF.md
# Prioritised Edge/Level Interrupt Controller

This block collects 32 interrupt request lines and presents two outgoing interrupt signals, one for normal interrupts (IRQ) and one for fast interrupts (FIQ). Each line has its own configuration word that gives it a 5-bit priority, chooses between latched-edge and level sensitivity, and steers it to one of the two outputs. A per-line pending bit records requests. A mask register blocks lines from arbitration. For each output class, an arbiter picks the eligible line with the numerically smallest priority. When the class is armed, that line's number is latched as the winner code and the output is raised.

Software works through a 32-bit word-access register port. It reads the winner code of a class to learn which line to service. For edge lines, that read also clears the line's pending bit. It then writes the control register to re-arm the class, which lowers the output and lets the next winner through. Pending bits can be cleared by writing zeros to the pending register. A software trigger register injects a request on one line.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the pending register reads 0, the mask reads 0xFFFFFFFF, every line-config word reads 0 (edge mode, IRQ class, priority 0), both winner codes read 0 and both outputs are low.
- R2: A line whose sensitivity bit is 0 (edge mode) sets its pending bit one clock after its input goes from low to high. The bit stays set after the input falls.
- R3: A line whose sensitivity bit is 1 (level mode) has its pending bit set one clock after it samples its input high. The bit is cleared one clock after the input falls.
- R4: A write to offset 0x00 ANDs the written word into the pending bits. A level-mode line whose recorded input is high keeps its bit.
- R5: A line whose mask bit (offset 0x04) is 1 never causes an output to rise. Writing the mask re-evaluates both classes, so unmasking a pending line raises its output two clocks after the write is presented.
- R6: The line-config word for line n sits at offset 0x1C + 4n. Bits [6:2] hold the priority, bit 1 holds the sensitivity (1 = level) and bit 0 holds the steering (1 = FIQ). It reads back in this layout, and bits [31:7] read 0.
- R7: Among the eligible lines of a class (pending, unmasked, steered to that class), the one with the smallest priority value wins. On equal priority, the higher line number wins.
- R8: When a class is armed and has an eligible line, its output rises on the next clock and its winner code (IRQ at 0x10, FIQ at 0x14) latches that line number. Both then hold until the class is re-armed.
- R9: A write to offset 0x18 with bit 0 set re-arms IRQ, and with bit 1 set re-arms FIQ. Re-arming lowers the output unless an eligible line exists, in which case the output stays high with a new code. Offset 0x18 reads 0.
- R10: Reading a winner code returns the latched line number. It clears that line's pending bit only when the line is in edge mode.
- R11: A write to offset 0x9C requests only the lowest-numbered set bit of the written word. The request follows the line's sensitivity rule, and the register reads 0.
- R12: Undefined offsets read 0 and ignore writes. Writes to 0x10 and 0x14 change nothing.
- R13: If a request sets a pending bit in the same cycle as a clearing write to that bit, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 32 | Interrupt request inputs, active high, synchronous to clk |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
Two functions can act on one pending bit in the same clock: a new request on an edge-mode line, and a software clear of that bit through a write to the pending register. The bench provokes this by raising the line's input on the same clock edge that it presents a write of all zeros to offset 0x00. It then reads the pending register and expects the bit to be set. A second coincidence is a re-arm write while further lines are still pending. The bench judges it by requiring the output to stay high and the winner code to advance to the next line in priority order.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int PRIO_W = 5;

  localparam logic [7:0] A_PEND   = 8'h00;
  localparam logic [7:0] A_MASK   = 8'h04;
  localparam logic [7:0] A_IRQ_ID = 8'h10;
  localparam logic [7:0] A_FIQ_ID = 8'h14;
  localparam logic [7:0] A_CTRL   = 8'h18;
  localparam logic [7:0] A_CFG0   = 8'h1C;
  localparam logic [7:0] A_CFGN   = 8'h98;
  localparam logic [7:0] A_SWTRIG = 8'h9C;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              level;
    logic              to_fiq;
  } line_cfg_t;
endpackage

// File: rtl/irq_line_cell.sv
module irq_line_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic level_i,
  input  logic sw_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  input  logic rd_clr_i,
  output logic pend_o
);
  logic in_q, pend_q, pend_d, set_c, clr_c, pend_en, in_en;

  always_comb begin
    if (level_i) begin
      set_c = line_i | sw_i;
      clr_c = (wr_i & ~wr_bit_i & ~in_q) | (in_q & ~line_i);
    end else begin
      set_c = (line_i | sw_i) & ~in_q;
      clr_c = (wr_i & ~wr_bit_i) | rd_clr_i;
    end
    pend_d  = set_c | (pend_q & ~clr_c);
    pend_en = set_c | clr_c;
    in_en   = line_i ^ in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (in_en)   in_q   <= line_i;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  p_level_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i && line_i) |=> pend_q);
  p_level_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i && in_q && !line_i && !sw_i) |=> !pend_q);
  p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && pend_q && !wr_i && !rd_clr_i) |=> pend_q);
  p_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && line_i && !in_q) |=> pend_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N  = 32,
  parameter int PW = 5,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]         elig_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  output logic                 any_o,
  output logic [IW-1:0]        win_o
);
  logic [PW-1:0] best;

  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!any_o || prio_i[i] <= best)) begin
        any_o = 1'b1;
        best  = prio_i[i];
        win_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_channel.sv
module irq_channel #(
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_i,
  input  logic [IW-1:0] win_i,
  input  logic          rearm_i,
  output logic          out_o,
  output logic [IW-1:0] code_o
);
  logic armed_q, armed_d, out_q, out_d, ch_en, armed_eff;
  logic [IW-1:0] code_q, code_d;

  always_comb begin
    armed_eff = armed_q | rearm_i;
    armed_d   = armed_q;
    out_d     = out_q;
    code_d    = code_q;
    if (rearm_i) begin
      armed_d = 1'b1;
      out_d   = 1'b0;
    end
    if (armed_eff && any_i) begin
      armed_d = 1'b0;
      out_d   = 1'b1;
      code_d  = win_i;
    end
    ch_en = rearm_i | (armed_eff & any_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
      code_q  <= '0;
    end else if (ch_en) begin
      armed_q <= armed_d;
      out_q   <= out_d;
      code_q  <= code_d;
    end
  end

  assign out_o  = out_q;
  assign code_o = code_q;

  p_rise_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(armed_q || rearm_i));
  p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && !rearm_i) |=> ($stable(code_q) && out_q));
  p_rearm_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_i && !any_i) |=> !out_q);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 32,
  localparam int IW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 irq_o,
  output logic                 fiq_o
);
  localparam int CW = $bits(line_cfg_t);

  logic wr_en, rd_en, is_cfg;
  logic [IW-1:0] cfg_idx;
  logic [NUM_LINES-1:0] pend, mask_q, mask_d, sw_vec, sw_low;
  logic [NUM_LINES-1:0] lvl_vec, fiq_vec, rd_clr;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_vec;
  line_cfg_t cfg_q [NUM_LINES];
  line_cfg_t cfg_d;
  logic cfg_we, mask_we, pend_we, rd_irq, rd_fiq, ctrl_we;
  logic [1:0] rearm, any_c, out_c;
  logic [1:0][NUM_LINES-1:0] elig;
  logic [1:0][IW-1:0] win_c, code_c;

  // decode
  always_comb begin
    wr_en   = bus_sel & bus_wr;
    rd_en   = bus_sel & ~bus_wr;
    is_cfg  = (bus_addr >= A_CFG0) && (bus_addr <= A_CFGN) && (bus_addr[1:0] == 2'b00);
    cfg_idx = IW'((bus_addr - A_CFG0) >> 2);
    cfg_we  = wr_en & is_cfg;
    mask_we = wr_en & (bus_addr == A_MASK);
    pend_we = wr_en & (bus_addr == A_PEND);
    ctrl_we = wr_en & (bus_addr == A_CTRL);
    rd_irq  = rd_en & (bus_addr == A_IRQ_ID);
    rd_fiq  = rd_en & (bus_addr == A_FIQ_ID);
    rearm   = {ctrl_we & bus_wdata[1], ctrl_we & bus_wdata[0]};
    sw_low  = bus_wdata[NUM_LINES-1:0] & (~bus_wdata[NUM_LINES-1:0] + 1'b1);
    sw_vec  = (wr_en && bus_addr == A_SWTRIG) ? sw_low : '0;
    mask_d  = bus_wdata[NUM_LINES-1:0];
    cfg_d   = line_cfg_t'(bus_wdata[CW-1:0]);
  end

  // configuration and mask storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      for (int i = 0; i < NUM_LINES; i++) cfg_q[i] <= '0;
    end else begin
      if (mask_we) mask_q <= mask_d;
      if (cfg_we)  cfg_q[cfg_idx] <= cfg_d;
    end
  end

  // per-line request state
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign lvl_vec[g]  = cfg_q[g].level;
    assign fiq_vec[g]  = cfg_q[g].to_fiq;
    assign prio_vec[g] = cfg_q[g].prio;
    assign rd_clr[g]   = (rd_irq && code_c[0] == IW'(g)) || (rd_fiq && code_c[1] == IW'(g));
    irq_line_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (line_in[g]),
      .level_i  (lvl_vec[g]),
      .sw_i     (sw_vec[g]),
      .wr_i     (pend_we),
      .wr_bit_i (bus_wdata[g]),
      .rd_clr_i (rd_clr[g]),
      .pend_o   (pend[g])
    );
  end

  // one arbiter and output channel per class: 0 = IRQ, 1 = FIQ
  for (genvar k = 0; k < 2; k++) begin : g_class
    assign elig[k] = pend & ~mask_q & ((k == 1) ? fiq_vec : ~fiq_vec);
    irq_arbiter #(.N(NUM_LINES), .PW(PRIO_W)) u_arb (
      .elig_i (elig[k]),
      .prio_i (prio_vec),
      .any_o  (any_c[k]),
      .win_o  (win_c[k])
    );
    irq_channel #(.IW(IW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_i   (any_c[k]),
      .win_i   (win_c[k]),
      .rearm_i (rearm[k]),
      .out_o   (out_c[k]),
      .code_o  (code_c[k])
    );
  end

  assign irq_o = out_c[0];
  assign fiq_o = out_c[1];

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (is_cfg)                      bus_rdata = 32'(cfg_q[cfg_idx]);
      else if (bus_addr == A_PEND)     bus_rdata = 32'(pend);
      else if (bus_addr == A_MASK)     bus_rdata = 32'(mask_q);
      else if (bus_addr == A_IRQ_ID)   bus_rdata = 32'(code_c[0]);
      else if (bus_addr == A_FIQ_ID)   bus_rdata = 32'(code_c[1]);
    end
  end

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1 && !mask_we && !irq_o) |=> !irq_o);
  p_sw_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sw_vec) <= 1);
endmodule

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] line_in = '0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o, fiq_o;
  int n_chk = 0, n_fail = 0;
  logic [31:0] v, v2;

  always #2 clk = ~clk;

  irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] cfga(input int n);
    return 8'(8'h1C + 4 * n);
  endfunction

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    // R1 reset state
    rd(8'h00, v); chk("R1 pending", v, 0);
    rd(8'h04, v); chk("R1 mask", v, 32'hFFFFFFFF);
    rd(cfga(0), v); chk("R1 cfg0", v, 0);
    rd(cfga(31), v); chk("R1 cfg31", v, 0);
    rd(8'h10, v); chk("R1 irq code", v, 0);
    rd(8'h14, v); chk("R1 fiq code", v, 0);
    chk("R1 outputs", {30'd0, fiq_o, irq_o}, 0);

    // R6 config layout sweep
    for (int i = 0; i < 32; i++) begin
      v2 = 32'((((i * 5) & 31) << 2) | ((i & 1) << 1) | ((i >> 1) & 1));
      wr(cfga(i), v2 | 32'hFFFFFF80);
      rd(cfga(i), v); chk("R6 cfg readback", v, v2);
    end
    for (int i = 0; i < 32; i++) wr(cfga(i), 0);

    // R2 edge mode sweep with mask all ones (R5 masked lines stay quiet)
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); line_in[i] = 1'b1;
      rd(8'h00, v); chk("R2 edge set", v, 32'(1) << i);
      @(negedge clk); line_in[i] = 1'b0;
      rd(8'h00, v); chk("R2 edge hold", v, 32'(1) << i);
      chk("R5 masked quiet", {31'd0, irq_o}, 0);
      wr(8'h00, ~(32'(1) << i));
      rd(8'h00, v); chk("R4 clear edge", v, 0);
    end

    // R3 and R4 level mode
    wr(cfga(5), 32'h2);
    @(negedge clk); line_in[5] = 1'b1;
    rd(8'h00, v); chk("R3 level set", v, 32'h20);
    wr(8'h00, 0);
    rd(8'h00, v); chk("R4 level kept", v, 32'h20);
    @(negedge clk); line_in[5] = 1'b0;
    rd(8'h00, v); chk("R3 level drop", v, 0);

    // R5 unmask re-evaluation, R8, R10, R9
    @(negedge clk); line_in[3] = 1'b1;
    cyc(2);
    chk("R5 pending masked", {31'd0, irq_o}, 0);
    wr(8'h04, ~32'h8);
    cyc(1);
    chk("R5 unmask raises irq", {30'd0, fiq_o, irq_o}, 32'h1);
    rd(8'h10, v); chk("R10 irq code", v, 3);
    rd(8'h00, v); chk("R10 edge cleared by read", v, 0);
    chk("R8 irq holds", {31'd0, irq_o}, 1);
    wr(8'h18, 32'h1);
    chk("R9 rearm drops", {31'd0, irq_o}, 0);
    rd(8'h18, v); chk("R9 ctrl reads 0", v, 0);
    line_in[3] = 1'b0;

    // R7 arbitration
    wr(8'h04, 0);
    wr(cfga(10), 32'h1C);
    wr(cfga(20), 32'h0C);
    wr(cfga(25), 32'h0C);
    @(negedge clk); line_in[10] = 1'b1; line_in[20] = 1'b1; line_in[25] = 1'b1;
    cyc(2);
    chk("R8 irq rises", {31'd0, irq_o}, 1);
    rd(8'h10, v); chk("R7 tie higher line", v, 25);
    wr(8'h18, 32'h1);
    chk("R9 rearm with pending keeps irq", {31'd0, irq_o}, 1);
    rd(8'h10, v); chk("R7 next priority", v, 20);
    wr(8'h18, 32'h1);
    rd(8'h10, v); chk("R7 lowest priority last", v, 10);
    wr(8'h18, 32'h1);
    chk("R9 irq low when empty", {31'd0, irq_o}, 0);
    line_in[10] = 1'b0; line_in[20] = 1'b0; line_in[25] = 1'b0;

    // FIQ class
    wr(cfga(7), 32'h1);
    @(negedge clk); line_in[7] = 1'b1;
    cyc(2);
    chk("R8 fiq only", {30'd0, fiq_o, irq_o}, 32'h2);
    rd(8'h14, v); chk("R10 fiq code", v, 7);
    wr(8'h18, 32'h2);
    chk("R9 fiq rearm", {30'd0, fiq_o, irq_o}, 0);
    line_in[7] = 1'b0;

    // R10 level line not cleared by read
    wr(cfga(8), 32'h2);
    @(negedge clk); line_in[8] = 1'b1;
    cyc(2);
    rd(8'h10, v); chk("R10 level code", v, 8);
    rd(8'h00, v); chk("R10 level kept after read", v, 32'h100);
    @(negedge clk); line_in[8] = 1'b0;
    rd(8'h00, v); chk("R3 level drop after read", v, 0);
    wr(8'h18, 32'h1);
    chk("R9 irq low", {31'd0, irq_o}, 0);

    // R11 software trigger
    wr(8'h04, 32'hFFFFFFFF);
    wr(8'h9C, 32'h00000C00);
    rd(8'h00, v); chk("R11 lowest bit only", v, 32'h400);
    rd(8'h9C, v); chk("R11 reads 0", v, 0);
    wr(8'h00, 0);
    rd(8'h00, v); chk("R11 cleared", v, 0);

    // R12 undefined and read-only offsets
    rd(8'h08, v); chk("R12 undefined reads 0", v, 0);
    wr(8'h08, 32'h12345678);
    rd(8'h04, v); chk("R12 write ignored", v, 32'hFFFFFFFF);
    rd(8'h10, v2);
    wr(8'h10, 32'h1F);
    rd(8'h10, v); chk("R12 code read-only", v, v2);
    rd(8'hFC, v); chk("R12 high offset reads 0", v, 0);

    // R13 set and clear in one cycle
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 0;
    line_in[12] = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(8'h00, v); chk("R13 set wins", v, 32'h1000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule